// File: doc/BRIEF.md
# Shared Interrupt Distributor with Per-Line Routing

This block is the global stage of a multiprocessor interrupt controller. It watches a set of shared external interrupt lines, turns each one into a pending condition according to a per-line trigger mode, and forwards every pending line either to one chosen CPU or, in broadcast mode, to every CPU whose local controller is enabled. Each CPU port presents a pending flag and the interrupt ID of the lowest-numbered line routed to it. Shared IDs start at 32, because IDs below 32 are private to each CPU and never reach this block.

Software configures the block through a simple valid/ready register port that covers a 0x8000-byte window. The per-CPU local windows sit directly above this window and are not decoded here. The window holds a global enable, packed 2-bit trigger fields, and one routing word per line. A local controller takes an edge-latched interrupt by pulsing its accept strobe while the interrupt is presented. Level-mode lines simply follow their input.

Top module: `shared_irq_dist`

## Requirements
- R1: After reset, every cpu_pend bit is 0 and every cpu_id field is 0. Reads return 0 for the enable, 0 for every trigger field (active-high level), and 0 for every routing word (CPU 0, broadcast off).
- R2: Register map, all offsets word aligned. The enable is bit 0 of offset 0x0. Trigger word w is at 0x100+4*w, and line k uses bits 2*(k mod 16)+1 : 2*(k mod 16) of word k/16. The routing word for line k is at 0x1000+4*k, with the CPU number in bits 7:0 and the broadcast flag in bit 31. Other offsets read as 0, and writes to them are ignored. reg_ready is always 1.
- R3: Trigger code 0 is active-high level and code 1 is active-low level. A level line is pending from the clock edge after its input reaches the active level, and stops being pending on the edge after it leaves that level.
- R4: Trigger code 2 latches a rising edge and code 3 latches a falling edge. The edge is sampled at a clock edge, is pending from that edge on, and stays pending after the input returns.
- R5: When cpu_take[c] is high while cpu_pend[c] is 1, the edge latch of the line presented on cpu_id[c] clears at that clock edge. Level lines are unaffected.
- R6: With the broadcast flag clear, a pending line is presented only to the CPU whose number is in its routing word. cpu_en does not matter in this case.
- R7: With the broadcast flag set, a pending line is presented to every CPU c with cpu_en[c]=1, and to no other CPU.
- R8: A routing word with the broadcast flag clear and a CPU number of NUM_CPUS or more delivers that line to no CPU.
- R9: Each CPU is shown the lowest-numbered line routed to it, as cpu_id = 32 + line index. cpu_id is 0 when cpu_pend is 0.
- R10: While the enable is 0, no cpu_pend bit is set, but edges are still latched. Setting the enable later presents them.
- R11: A write to a routing word or a trigger word changes the outputs from the clock edge that accepts the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_valid | input | 1 | Register access request |
| reg_ready | output | 1 | Access accepted (always 1) |
| reg_write | input | 1 | 1 for write, 0 for read |
| reg_addr | input | 15 | Byte offset in the window |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| irq_in | input | 32 | Shared interrupt lines, synchronous to clk |
| cpu_en | input | 4 | Local controller enabled, per CPU |
| cpu_take | input | 4 | Accept strobe, per CPU |
| cpu_pend | output | 4 | Interrupt presented, per CPU |
| cpu_id | output | 24 | Presented ID, 6 bits per CPU, CPU c at bits 6c+5:6c |

## Verification
A corrupted edge latch or sampled-input register shows up as a wrong cpu_pend or cpu_id on the CPU that owns the line, one cycle after the input event that should have changed it. A wrong routing or trigger field shows in the cycle after the write that set it. The bench therefore compares every CPU port against a reference model once per clock. This catches a divergence in the first cycle it reaches a port, even when the corrupted line is hidden behind a lower-numbered pending line until that one is accepted.

// File: rtl/sdist_pkg.sv
package sdist_pkg;
  typedef enum logic [1:0] {
    TRIG_LVL_HI = 2'd0,
    TRIG_LVL_LO = 2'd1,
    TRIG_RISE   = 2'd2,
    TRIG_FALL   = 2'd3
  } trig_e;

  localparam int unsigned SHARED_BASE    = 32;
  localparam int unsigned LINES_PER_WORD = 16;
  localparam int unsigned OFS_CTRL       = 32'h0000;
  localparam int unsigned OFS_TRIG       = 32'h0100;
  localparam int unsigned OFS_ROUTE      = 32'h1000;
  localparam int unsigned BCAST_BIT      = 31;
endpackage

// File: rtl/sdist_regs.sv
module sdist_regs
  import sdist_pkg::*;
#(
  parameter int NUM_LINES = 32,
  parameter int CPU_W     = 8,
  parameter int ADDR_W    = 15
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             req_valid,
  input  logic                             req_write,
  input  logic [ADDR_W-1:0]                req_addr,
  input  logic [31:0]                      req_wdata,
  output logic [31:0]                      req_rdata,
  output logic                             glob_en,
  output logic [NUM_LINES-1:0][1:0]        trig_cfg,
  output logic [NUM_LINES-1:0][CPU_W-1:0]  tgt_cpu,
  output logic [NUM_LINES-1:0]             tgt_bcast
);
  localparam int TWORDS = (NUM_LINES + LINES_PER_WORD - 1) / LINES_PER_WORD;
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_TRIG  = ADDR_W'(OFS_TRIG);
  localparam logic [ADDR_W-1:0] A_ROUTE = ADDR_W'(OFS_ROUTE);

  logic [ADDR_W-1:0] trig_rel, route_rel;
  logic [ADDR_W-3:0] trig_idx, route_idx;
  logic in_ctrl, in_trig, in_route, wr_fire;

  logic                            en_q, en_d;
  logic [NUM_LINES-1:0][1:0]       trig_q, trig_d;
  logic [NUM_LINES-1:0][CPU_W-1:0] cpu_q, cpu_d;
  logic [NUM_LINES-1:0]            bc_q, bc_d;

  assign trig_rel  = req_addr - A_TRIG;
  assign route_rel = req_addr - A_ROUTE;
  assign trig_idx  = trig_rel[ADDR_W-1:2];
  assign route_idx = route_rel[ADDR_W-1:2];

  assign in_ctrl  = (req_addr == A_CTRL);
  assign in_trig  = (req_addr >= A_TRIG) && (trig_idx < (ADDR_W-2)'(TWORDS))
                    && (req_addr[1:0] == 2'b00);
  assign in_route = (req_addr >= A_ROUTE) && (route_idx < (ADDR_W-2)'(NUM_LINES))
                    && (req_addr[1:0] == 2'b00);
  assign wr_fire  = req_valid && req_write;

  // next state
  always_comb begin
    en_d   = en_q;
    trig_d = trig_q;
    cpu_d  = cpu_q;
    bc_d   = bc_q;
    if (in_ctrl) en_d = req_wdata[0];
    for (int n = 0; n < NUM_LINES; n++) begin
      if (in_trig && trig_idx == (ADDR_W-2)'(n / LINES_PER_WORD))
        trig_d[n] = req_wdata[(n % LINES_PER_WORD)*2 +: 2];
      if (in_route && route_idx == (ADDR_W-2)'(n)) begin
        cpu_d[n] = req_wdata[CPU_W-1:0];
        bc_d[n]  = req_wdata[BCAST_BIT];
      end
    end
  end

  // read mux
  always_comb begin
    req_rdata = '0;
    if (in_ctrl) req_rdata[0] = en_q;
    for (int n = 0; n < NUM_LINES; n++) begin
      if (in_trig && trig_idx == (ADDR_W-2)'(n / LINES_PER_WORD))
        req_rdata[(n % LINES_PER_WORD)*2 +: 2] = trig_q[n];
      if (in_route && route_idx == (ADDR_W-2)'(n)) begin
        req_rdata[CPU_W-1:0] = cpu_q[n];
        req_rdata[BCAST_BIT] = bc_q[n];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      trig_q <= '0;
      cpu_q  <= '0;
      bc_q   <= '0;
    end else if (wr_fire) begin
      en_q   <= en_d;
      trig_q <= trig_d;
      cpu_q  <= cpu_d;
      bc_q   <= bc_d;
    end
  end

  assign glob_en   = en_q;
  assign trig_cfg  = trig_q;
  assign tgt_cpu   = cpu_q;
  assign tgt_bcast = bc_q;

  // R2
  ctrl_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && in_ctrl) |=> (glob_en == $past(req_wdata[0])));

  for (genvar n = 0; n < NUM_LINES; n++) begin : g_route_chk
    // R11
    route_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_fire && in_route && route_idx == (ADDR_W-2)'(n))
      |=> (tgt_cpu[n] == $past(req_wdata[CPU_W-1:0])));
  end
endmodule

// File: rtl/sdist_detect.sv
module sdist_detect
  import sdist_pkg::*;
#(
  parameter int NUM_LINES = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_LINES-1:0]      irq_in,
  input  logic [NUM_LINES-1:0][1:0] trig_cfg,
  input  logic [NUM_LINES-1:0]      clr,
  output logic [NUM_LINES-1:0]      active
);
  logic [NUM_LINES-1:0] samp_q, edge_q, edge_d;
  logic [NUM_LINES-1:0] rise, fall;

  assign rise = irq_in & ~samp_q;
  assign fall = ~irq_in & samp_q;

  always_comb begin
    for (int n = 0; n < NUM_LINES; n++) begin
      case (trig_e'(trig_cfg[n]))
        TRIG_LVL_HI: begin active[n] = samp_q[n];  edge_d[n] = 1'b0; end
        TRIG_LVL_LO: begin active[n] = ~samp_q[n]; edge_d[n] = 1'b0; end
        TRIG_RISE:   begin active[n] = edge_q[n];
                           edge_d[n] = (edge_q[n] & ~clr[n]) | rise[n]; end
        default:     begin active[n] = edge_q[n];
                           edge_d[n] = (edge_q[n] & ~clr[n]) | fall[n]; end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp_q <= '0;
      edge_q <= '0;
    end else begin
      samp_q <= irq_in;
      edge_q <= edge_d;
    end
  end

  for (genvar n = 0; n < NUM_LINES; n++) begin : g_chk
    // R4
    rise_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_cfg[n] == TRIG_RISE && rise[n])
      |=> (active[n] || trig_cfg[n] != TRIG_RISE));
    // R5
    edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_cfg[n][1] && edge_q[n] && !clr[n])
      |=> (edge_q[n] || !trig_cfg[n][1]));
  end
endmodule

// File: rtl/sdist_route.sv
module sdist_route
  import sdist_pkg::*;
#(
  parameter int NUM_LINES = 32,
  parameter int NUM_CPUS  = 4,
  parameter int CPU_W     = 8,
  parameter int ID_W      = 6,
  parameter int LW        = 5
) (
  input  logic                            glob_en,
  input  logic [NUM_LINES-1:0]            active,
  input  logic [NUM_LINES-1:0][CPU_W-1:0] tgt_cpu,
  input  logic [NUM_LINES-1:0]            tgt_bcast,
  input  logic [NUM_CPUS-1:0]             cpu_en,
  input  logic [NUM_CPUS-1:0]             cpu_take,
  output logic [NUM_CPUS-1:0]             cpu_pend,
  output logic [NUM_CPUS-1:0][ID_W-1:0]   cpu_id,
  output logic [NUM_LINES-1:0]            clr
);
  logic [NUM_CPUS-1:0][LW-1:0] take_sel;
  logic [NUM_CPUS-1:0]         take_hit;

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
    logic [NUM_LINES-1:0] elig;
    logic                 hit;
    logic [LW-1:0]        sel;

    always_comb begin
      for (int n = 0; n < NUM_LINES; n++)
        elig[n] = glob_en && active[n] &&
                  (tgt_bcast[n] ? cpu_en[c] : (tgt_cpu[n] == CPU_W'(c)));
    end

    // lowest index wins
    always_comb begin
      hit = 1'b0;
      sel = '0;
      for (int n = NUM_LINES-1; n >= 0; n--) begin
        if (elig[n]) begin
          hit = 1'b1;
          sel = LW'(n);
        end
      end
    end

    assign cpu_pend[c] = hit;
    assign cpu_id[c]   = hit ? (ID_W'(SHARED_BASE) + ID_W'(sel)) : '0;
    assign take_sel[c] = sel;
    assign take_hit[c] = hit && cpu_take[c];
  end

  always_comb begin
    clr = '0;
    for (int c = 0; c < NUM_CPUS; c++)
      for (int n = 0; n < NUM_LINES; n++)
        if (take_hit[c] && take_sel[c] == LW'(n)) clr[n] = 1'b1;
  end
endmodule

// File: rtl/shared_irq_dist.sv
module shared_irq_dist
  import sdist_pkg::*;
#(
  parameter  int NUM_LINES = 32,
  parameter  int NUM_CPUS  = 4,
  parameter  int CPU_W     = 8,
  parameter  int ADDR_W    = 15,
  localparam int ID_W      = $clog2(SHARED_BASE + NUM_LINES),
  localparam int LW        = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     reg_valid,
  output logic                     reg_ready,
  input  logic                     reg_write,
  input  logic [ADDR_W-1:0]        reg_addr,
  input  logic [31:0]              reg_wdata,
  output logic [31:0]              reg_rdata,
  input  logic [NUM_LINES-1:0]     irq_in,
  input  logic [NUM_CPUS-1:0]      cpu_en,
  input  logic [NUM_CPUS-1:0]      cpu_take,
  output logic [NUM_CPUS-1:0]      cpu_pend,
  output logic [NUM_CPUS*ID_W-1:0] cpu_id
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic                            glob_en;
  logic [NUM_LINES-1:0][1:0]       trig_cfg;
  logic [NUM_LINES-1:0][CPU_W-1:0] tgt_cpu;
  logic [NUM_LINES-1:0]            tgt_bcast;
  logic [NUM_LINES-1:0]            active, clr;
  logic [NUM_CPUS-1:0][ID_W-1:0]   id_arr;

  assign reg_ready = 1'b1;

  sdist_regs #(.NUM_LINES(NUM_LINES), .CPU_W(CPU_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_int_n),
    .req_valid(reg_valid), .req_write(reg_write),
    .req_addr(reg_addr), .req_wdata(reg_wdata), .req_rdata(reg_rdata),
    .glob_en(glob_en), .trig_cfg(trig_cfg),
    .tgt_cpu(tgt_cpu), .tgt_bcast(tgt_bcast)
  );

  sdist_detect #(.NUM_LINES(NUM_LINES)) u_detect (
    .clk(clk), .rst_n(rst_int_n), .irq_in(irq_in),
    .trig_cfg(trig_cfg), .clr(clr), .active(active)
  );

  sdist_route #(.NUM_LINES(NUM_LINES), .NUM_CPUS(NUM_CPUS), .CPU_W(CPU_W),
                .ID_W(ID_W), .LW(LW)) u_route (
    .glob_en(glob_en), .active(active), .tgt_cpu(tgt_cpu),
    .tgt_bcast(tgt_bcast), .cpu_en(cpu_en), .cpu_take(cpu_take),
    .cpu_pend(cpu_pend), .cpu_id(id_arr), .clr(clr)
  );

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_id
    assign cpu_id[c*ID_W +: ID_W] = id_arr[c];
  end

  // R10
  gate_off_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !glob_en |-> (cpu_pend == '0));
endmodule

// File: tb/shared_irq_dist_test.sv
module shared_irq_dist_test;
  localparam int NL = 32;
  localparam int NC = 4;
  localparam int AW = 15;
  localparam int IW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_valid = 1'b0, reg_write = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [NL-1:0] irq_in = '0;
  logic [NC-1:0] cpu_en = '0, cpu_take = '0;
  logic reg_ready;
  logic [31:0] reg_rdata;
  logic [NC-1:0] cpu_pend;
  logic [NC*IW-1:0] cpu_id;

  int tests = 0, fails = 0;
  string phase = "R1";
  bit done = 0;

  always #10 clk = ~clk;

  shared_irq_dist uut (
    .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_ready(reg_ready),
    .reg_write(reg_write), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_in(irq_in), .cpu_en(cpu_en),
    .cpu_take(cpu_take), .cpu_pend(cpu_pend), .cpu_id(cpu_id)
  );

  // reference model state
  int m_trig[NL];
  int m_tgt[NL];
  bit m_bc[NL];
  bit m_lat[NL];
  bit m_s[NL];
  bit m_en;

  function automatic void model_out(input int c, output bit p, output int id);
    p = 0; id = 0;
    for (int n = NL-1; n >= 0; n--) begin
      bit act, el;
      case (m_trig[n])
        0: act = m_s[n];
        1: act = !m_s[n];
        default: act = m_lat[n];
      endcase
      el = m_bc[n] ? bit'(cpu_en[c]) : (m_tgt[n] == c);
      if (m_en && act && el) begin p = 1; id = 32 + n; end
    end
  endfunction

  always @(posedge clk) begin : mdl
    bit clr_v [NL];
    bit p;
    int id;
    if (!rst_n) begin
      m_en = 0;
      for (int n = 0; n < NL; n++) begin
        m_trig[n] = 0; m_tgt[n] = 0; m_bc[n] = 0; m_lat[n] = 0; m_s[n] = 0;
      end
    end else begin
      for (int n = 0; n < NL; n++) clr_v[n] = 0;
      for (int c = 0; c < NC; c++) begin
        model_out(c, p, id);
        if (p && cpu_take[c]) clr_v[id-32] = 1;
      end
      for (int n = 0; n < NL; n++) begin
        if (m_trig[n] == 2)
          m_lat[n] = (m_lat[n] && !clr_v[n]) || (irq_in[n] && !m_s[n]);
        else if (m_trig[n] == 3)
          m_lat[n] = (m_lat[n] && !clr_v[n]) || (!irq_in[n] && m_s[n]);
        else
          m_lat[n] = 0;
      end
      if (reg_valid && reg_write) begin
        int a;
        a = int'(reg_addr);
        if (a == 0) m_en = reg_wdata[0];
        if (a >= 'h100 && a < 'h108 && a % 4 == 0)
          for (int k = 0; k < 16; k++)
            m_trig[(a-'h100)/4*16 + k] = int'(reg_wdata[2*k +: 2]);
        if (a >= 'h1000 && a < 'h1000 + 4*NL && a % 4 == 0) begin
          m_tgt[(a-'h1000)/4] = int'(reg_wdata[7:0]);
          m_bc[(a-'h1000)/4]  = reg_wdata[31];
        end
      end
      for (int n = 0; n < NL; n++) m_s[n] = irq_in[n];
    end
  end

  // per-cycle comparison, midway between a falling and a rising edge
  always begin
    @(negedge clk);
    #5;
    for (int c = 0; c < NC; c++) begin
      bit p;
      int id;
      model_out(c, p, id);
      tests++;
      if (cpu_pend[c] !== p || int'(cpu_id[c*IW +: IW]) != id) begin
        fails++;
        $display("FAIL %s cpu%0d pend=%0d id=%0d expected pend=%0d id=%0d",
                 phase, c, cpu_pend[c], cpu_id[c*IW +: IW], p, id);
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_valid = 1; reg_write = 1; reg_addr = AW'(a); reg_wdata = d;
    @(negedge clk);
    reg_valid = 0; reg_write = 0;
  endtask

  task automatic rd(input int a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    reg_valid = 1; reg_write = 0; reg_addr = AW'(a);
    #2;
    tests++;
    if (reg_rdata !== exp || reg_ready !== 1'b1) begin
      fails++;
      $display("FAIL %s read 0x%0h got %h ready=%0d expected %h ready=1",
               tag, a, reg_rdata, reg_ready, exp);
    end
    @(negedge clk);
    reg_valid = 0;
  endtask

  task automatic expect_cpu(input int c, input bit p, input int id, input string tag);
    #5;
    tests++;
    if (cpu_pend[c] !== p || int'(cpu_id[c*IW +: IW]) != id) begin
      fails++;
      $display("FAIL %s cpu%0d pend=%0d id=%0d expected pend=%0d id=%0d",
               tag, c, cpu_pend[c], cpu_id[c*IW +: IW], p, id);
    end
    @(negedge clk);
  endtask

  task automatic take(input logic [NC-1:0] m);
    @(negedge clk);
    cpu_take = m;
    @(negedge clk);
    cpu_take = '0;
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    idle(4);
    rst_n = 1;
    idle(4);
    // R1 reset state
    phase = "R1";
    for (int c = 0; c < NC; c++) expect_cpu(c, 0, 0, "R1");
    rd('h0, 0, "R1"); rd('h100, 0, "R1"); rd('h1000, 0, "R1");
    // R2 register map
    phase = "R2";
    wr('h0, 32'h1); rd('h0, 32'h1, "R2");
    wr('h1000 + 4*5, 32'h2); rd('h1000 + 4*5, 32'h2, "R2");
    wr('h1000 + 4*6, 32'h8000_00ff); rd('h1000 + 4*6, 32'h8000_00ff, "R2");
    wr('h1000 + 4*6, 32'h0);
    rd('h200, 0, "R2"); rd('h1000 + 4*NL, 0, "R2");
    wr('h104, 32'hA5A5_0000); rd('h104, 32'hA5A5_0000, "R2");
    wr('h104, 32'h0);
    // R3 + R6: line 5 level high to CPU 2, cpu_en all clear
    phase = "R6";
    irq_in[5] = 1; idle(2);
    expect_cpu(2, 1, 37, "R6"); expect_cpu(0, 0, 0, "R6");
    // R11 retarget to CPU 1
    phase = "R11";
    wr('h1000 + 4*5, 32'h1);
    expect_cpu(1, 1, 37, "R11"); expect_cpu(2, 0, 0, "R11");
    // R9 lowest first
    phase = "R9";
    wr('h1000 + 4*3, 32'h1); irq_in[3] = 1; idle(2);
    expect_cpu(1, 1, 35, "R9");
    irq_in[3] = 0; irq_in[5] = 0; idle(2);
    expect_cpu(1, 0, 0, "R9");
    // R3 level low on line 12
    phase = "R3";
    wr('h100, 32'h0100_0000);
    expect_cpu(0, 1, 44, "R3");
    irq_in[12] = 1; idle(2);
    expect_cpu(0, 0, 0, "R3");
    // R4 rising on line 10
    phase = "R4";
    wr('h100, 32'h0120_0000);
    irq_in[10] = 1; @(negedge clk); irq_in[10] = 0; idle(3);
    expect_cpu(0, 1, 42, "R4");
    // R5 accept clears
    phase = "R5";
    take(4'b0001); idle(1);
    expect_cpu(0, 0, 0, "R5");
    // R4 falling on line 20 to CPU 3
    phase = "R4";
    wr('h104, 32'h0000_0300); wr('h1000 + 4*20, 32'h3);
    irq_in[20] = 1; idle(2);
    expect_cpu(3, 0, 0, "R4");
    irq_in[20] = 0; idle(3);
    expect_cpu(3, 1, 52, "R4");
    phase = "R5";
    take(4'b1000); idle(1);
    expect_cpu(3, 0, 0, "R5");
    // R7 broadcast on line 7
    phase = "R7";
    wr('h1000 + 4*7, 32'h8000_0000);
    cpu_en = 4'b1011; irq_in[7] = 1; idle(2);
    expect_cpu(0, 1, 39, "R7"); expect_cpu(1, 1, 39, "R7");
    expect_cpu(3, 1, 39, "R7"); expect_cpu(2, 0, 0, "R7");
    cpu_en = 4'b0100; idle(1);
    expect_cpu(2, 1, 39, "R7"); expect_cpu(0, 0, 0, "R7");
    irq_in[7] = 0; idle(1);
    // R8 out-of-range target
    phase = "R8";
    wr('h1000 + 4*9, 32'h4); irq_in[9] = 1; idle(2);
    for (int c = 0; c < NC; c++) expect_cpu(c, 0, 0, "R8");
    wr('h1000 + 4*9, 32'h9); idle(1);
    for (int c = 0; c < NC; c++) expect_cpu(c, 0, 0, "R8");
    irq_in[9] = 0; idle(1);
    // R10 disabled still latches
    phase = "R10";
    wr('h0, 32'h0);
    irq_in[10] = 1; @(negedge clk); irq_in[10] = 0; idle(2);
    expect_cpu(0, 0, 0, "R10");
    wr('h0, 32'h1);
    expect_cpu(0, 1, 42, "R10");
    take(4'b0001); idle(1);
    // random traffic, model compared every cycle
    phase = "R9";
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      irq_in = NL'($urandom);
      cpu_en = NC'($urandom);
      cpu_take = NC'($urandom);
      if (i % 25 == 0)
        wr('h1000 + 4*int'($urandom % NL),
           {1'($urandom % 4 == 0), 23'b0, 8'($urandom % 6)});
      if (i % 90 == 0) wr('h100 + 4*int'($urandom % 2), $urandom);
    end
    cpu_take = '0;
    idle(3);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule